// File: doc/BRIEF.md
# Pairwise SIMD Integer Unit

This block executes vector pairwise integer instructions: wrapping addition, signed and unsigned maximum, and signed and unsigned minimum, on elements of 8, 16, 32 or 64 bits. An instruction names two source registers and a destination register in a 32-register file of 128-bit vectors held inside the block. The two sources are joined end to end, the second above the first, and each adjacent pair of elements in that joined value is combined into one result element. Pairs drawn from the first source fill the low half of the result and pairs from the second source fill the high half.

A narrow form uses only the low 64 bits of each source, produces a 64-bit result and clears the upper half of the destination. Encodings that name an unsupported opcode or an illegal combination of element size, signedness and width raise an undefined flag and leave the destination untouched. A load port and a combinational read port let the surrounding logic fill and inspect the register file.

Top module: `pairwise_simd_unit`

## Requirements
- R1: Opcode field instr[15:11] = 0x17 with instr[29] = 0 is pairwise add; each result element is the sum of its pair modulo 2^W, where the element width W is 8 << instr[23:22].
- R2: Opcode 0x14 is pairwise maximum and 0x15 pairwise minimum; instr[29] = 1 compares as unsigned, instr[29] = 0 as two's complement signed.
- R3: With instr[30] = 1, result element j is formed from elements 2j and 2j+1 of the 256-bit value {second source, first source}; the second source register is instr[20:16], the first instr[9:5], the destination instr[4:0].
- R4: With instr[30] = 0, only bits 63:0 of each source are used, result element j comes from elements 2j and 2j+1 of {second[63:0], first[63:0]}, and destination bits 127:64 are written as zero.
- R5: For 64-bit elements (size 3, Q = 1) with add, destination bits 63:0 hold the sum of the first source's two halves and bits 127:64 the sum of the second source's two halves.
- R6: Size 3 with Q = 0 raises undef in the done cycle and leaves the destination register unchanged.
- R7: Maximum or minimum with size 3, and add with instr[29] = 1, raise undef and leave the destination unchanged.
- R8: Any opcode other than 0x14, 0x15 and 0x17 raises undef and leaves the destination unchanged.
- R9: An instruction presented with in_valid at a rising edge makes done high for exactly the following clock cycle; the destination holds the result after the next rising edge.
- R10: After reset done and undef are low and every register reads zero.
- R11: ld_en at a rising edge writes ld_data into register ld_addr; peek_data always shows register peek_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| ld_en | input | 1 | Register load strobe |
| ld_addr | input | 5 | Register load index |
| ld_data | input | 128 | Register load value |
| peek_addr | input | 5 | Register read index |
| peek_data | output | 128 | Register read value |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | Illegal encoding, valid with done |

## Verification
The hardest situations to reach are the signed comparisons at the extremes of each element width, where the most negative and most positive values sit next to each other, and the illegal combinations that must leave a register untouched. The bench sweeps every opcode class, signedness bit, element size and width flag against source patterns that include sign-boundary values, and preloads the destination with a distinct marker before each instruction so that a stray write on an illegal encoding shows up at the read port.

// File: rtl/psu_pkg.sv
package psu_pkg;
   typedef enum logic [1:0] {OP_ADD = 2'd0, OP_MAX = 2'd1, OP_MIN = 2'd2} pop_e;

   localparam logic [4:0] OPC_ADD = 5'h17;
   localparam logic [4:0] OPC_MAX = 5'h14;
   localparam logic [4:0] OPC_MIN = 5'h15;

   typedef struct packed {
      pop_e       op;
      logic       uns;
      logic       q;
      logic [1:0] size;
      logic [4:0] src_lo;
      logic [4:0] src_hi;
      logic [4:0] dst;
      logic       illegal;
   } dec_t;
endpackage

// File: rtl/psu_decode.sv
module psu_decode
   import psu_pkg::*;
(
   input  logic [31:0] instr,
   output dec_t        dec
);
   logic [4:0] opc;
   logic       known;

   always_comb begin
      opc         = instr[15:11];
      dec.q       = instr[30];
      dec.uns     = instr[29];
      dec.size    = instr[23:22];
      dec.src_hi  = instr[20:16];
      dec.src_lo  = instr[9:5];
      dec.dst     = instr[4:0];
      known       = 1'b1;
      case (opc)
         OPC_ADD: dec.op = OP_ADD;
         OPC_MAX: dec.op = OP_MAX;
         OPC_MIN: dec.op = OP_MIN;
         default: begin
            dec.op = OP_ADD;
            known  = 1'b0;
         end
      endcase
      dec.illegal = !known
                 || (dec.size == 2'd3 && !dec.q)
                 || (dec.op != OP_ADD && dec.size == 2'd3)
                 || (dec.op == OP_ADD && dec.uns);
   end
endmodule

// File: rtl/psu_pair_alu.sv
module psu_pair_alu
   import psu_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  pop_e         op,
   input  logic         uns,
   output logic [W-1:0] r
);
   logic x_gt;

   always_comb begin
      x_gt = uns ? (x > y) : ($signed(x) > $signed(y));
      case (op)
         OP_MAX:  r = x_gt ? x : y;
         OP_MIN:  r = x_gt ? y : x;
         default: r = x + y;
      endcase
   end
endmodule

// File: rtl/psu_datapath.sv
module psu_datapath
   import psu_pkg::*;
#(
   parameter int VEC_W    = 128,
   parameter int ELEM_MIN = 8
) (
   input  logic [VEC_W-1:0] src_lo,
   input  logic [VEC_W-1:0] src_hi,
   input  logic             q,
   input  logic [1:0]       size,
   input  pop_e             op,
   input  logic             uns,
   output logic [VEC_W-1:0] res
);
   localparam int HALF   = VEC_W / 2;
   localparam int CAT_W  = 2 * VEC_W;
   localparam int NSIZES = 4;

   logic [CAT_W-1:0]              joined;
   logic [NSIZES-1:0][VEC_W-1:0]  by_size;
   logic [VEC_W-1:0]              picked;

   always_comb begin
      if (q) joined = {src_hi, src_lo};
      else   joined = {{VEC_W{1'b0}}, src_hi[HALF-1:0], src_lo[HALF-1:0]};
   end

   for (genvar s = 0; s < NSIZES; s++) begin : g_size
      localparam int W = ELEM_MIN << s;
      localparam int N = VEC_W / W;
      for (genvar e = 0; e < N; e++) begin : g_elem
         logic [W-1:0] r_e;
         psu_pair_alu #(.W(W)) u_alu (
            .x   (joined[(2*e)*W +: W]),
            .y   (joined[(2*e+1)*W +: W]),
            .op  (op),
            .uns (uns),
            .r   (r_e)
         );
         assign by_size[s][e*W +: W] = r_e;
      end
   end

   always_comb begin
      picked = by_size[size];
      res    = q ? picked : {{HALF{1'b0}}, picked[HALF-1:0]};
   end
endmodule

// File: rtl/psu_regfile.sv
module psu_regfile #(
   parameter int REGS  = 32,
   parameter int VEC_W = 128,
   localparam int AW   = $clog2(REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [AW-1:0]    ld_addr,
   input  logic [VEC_W-1:0] ld_data,
   input  logic             ex_en,
   input  logic [AW-1:0]    ex_addr,
   input  logic [VEC_W-1:0] ex_data,
   input  logic [AW-1:0]    ra_addr,
   output logic [VEC_W-1:0] ra_data,
   input  logic [AW-1:0]    rb_addr,
   output logic [VEC_W-1:0] rb_data,
   input  logic [AW-1:0]    rc_addr,
   output logic [VEC_W-1:0] rc_data
);
   logic [VEC_W-1:0] mem [REGS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < REGS; i++) mem[i] <= '0;
      end else begin
         if (ld_en) mem[ld_addr] <= ld_data;
         if (ex_en) mem[ex_addr] <= ex_data;
      end
   end

   assign ra_data = mem[ra_addr];
   assign rb_data = mem[rb_addr];
   assign rc_data = mem[rc_addr];
endmodule

// File: rtl/pairwise_simd_unit.sv
module pairwise_simd_unit
   import psu_pkg::*;
#(
   parameter int REGS     = 32,
   parameter int VEC_W    = 128,
   parameter int ELEM_MIN = 8,
   localparam int AW      = $clog2(REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [31:0]      instr,
   input  logic             ld_en,
   input  logic [AW-1:0]    ld_addr,
   input  logic [VEC_W-1:0] ld_data,
   input  logic [AW-1:0]    peek_addr,
   output logic [VEC_W-1:0] peek_data,
   output logic             done,
   output logic             undef
);
   if (VEC_W != 128)                 $error("VEC_W must be 128");
   if (ELEM_MIN != 8)                $error("ELEM_MIN must be 8");
   if (REGS < 2 || REGS > 32)        $error("REGS must be 2..32");
   if ((REGS & (REGS - 1)) != 0)     $error("REGS must be a power of two");

   dec_t             dec;
   logic [VEC_W-1:0] lo_val, hi_val, res_c;

   logic             stg_valid;
   logic             stg_undef;
   logic             stg_q;
   logic [AW-1:0]    stg_dst;
   logic [VEC_W-1:0] stg_res;

   psu_decode u_dec (.instr(instr), .dec(dec));

   psu_regfile #(.REGS(REGS), .VEC_W(VEC_W)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (ld_en),
      .ld_addr (ld_addr),
      .ld_data (ld_data),
      .ex_en   (stg_valid && !stg_undef),
      .ex_addr (stg_dst),
      .ex_data (stg_res),
      .ra_addr (dec.src_lo[AW-1:0]),
      .ra_data (lo_val),
      .rb_addr (dec.src_hi[AW-1:0]),
      .rb_data (hi_val),
      .rc_addr (peek_addr),
      .rc_data (peek_data)
   );

   psu_datapath #(.VEC_W(VEC_W), .ELEM_MIN(ELEM_MIN)) u_dp (
      .src_lo (lo_val),
      .src_hi (hi_val),
      .q      (dec.q),
      .size   (dec.size),
      .op     (dec.op),
      .uns    (dec.uns),
      .res    (res_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_valid <= 1'b0;
         stg_undef <= 1'b0;
         stg_q     <= 1'b0;
         stg_dst   <= '0;
         stg_res   <= '0;
      end else begin
         stg_valid <= in_valid;
         if (in_valid) begin
            stg_undef <= dec.illegal;
            stg_q     <= dec.q;
            stg_dst   <= dec.dst[AW-1:0];
            stg_res   <= res_c;
         end
      end
   end

   assign done  = stg_valid;
   assign undef = stg_valid && stg_undef;
endmodule

// File: rtl/psu_checker.sv
module psu_checker #(
   parameter int VEC_W = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [31:0]      instr,
   input logic             done,
   input logic             undef,
   input logic             stg_q,
   input logic [VEC_W-1:0] stg_res
);
   localparam int HALF = VEC_W / 2;

   logic [4:0] opc;
   assign opc = instr[15:11];

   assert_done_after_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> done);

   assert_done_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(in_valid));

   assert_undef_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      undef |-> done);

   assert_narrow_size3_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[23:22] == 2'd3 && !instr[30]) |=> undef);

   assert_bad_combo_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (((opc == 5'h14 || opc == 5'h15) && instr[23:22] == 2'd3)
                    || (opc == 5'h17 && instr[29]))) |=> undef);

   assert_bad_opcode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opc != 5'h14 && opc != 5'h15 && opc != 5'h17) |=> undef);

   assert_add_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opc == 5'h17 && !instr[29] && !(instr[23:22] == 2'd3 && !instr[30]))
      |=> !undef);

   assert_narrow_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !undef && !stg_q) |-> (stg_res[VEC_W-1:HALF] == '0));
endmodule

bind pairwise_simd_unit psu_checker #(.VEC_W(VEC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .instr    (instr),
   .done     (done),
   .undef    (undef),
   .stg_q    (stg_q),
   .stg_res  (stg_res)
);

// File: tb/tb_pairwise_simd_unit.sv
module tb_pairwise_simd_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [31:0]  instr = '0;
   logic         ld_en = 1'b0;
   logic [4:0]   ld_addr = '0;
   logic [127:0] ld_data = '0;
   logic [4:0]   peek_addr = '0;
   logic [127:0] peek_data;
   logic         done, undef;

   int total = 0;
   int bad   = 0;
   logic [127:0] shadow [32];

   always #4 clk = ~clk;

   pairwise_simd_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
      .peek_addr(peek_addr), .peek_data(peek_data),
      .done(done), .undef(undef)
   );

   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic load(input logic [4:0] a, input logic [127:0] v);
      @(negedge clk);
      ld_en = 1'b1; ld_addr = a; ld_data = v;
      @(negedge clk);
      ld_en = 1'b0;
      shadow[a] = v;
   endtask

   // Reference: expected legality and destination value, from the requirements.
   function automatic logic [128:0] model(input logic [127:0] a, input logic [127:0] b,
                                          input bit q, input bit u, input int sz,
                                          input logic [4:0] opc);
      logic [255:0] cat;
      logic [127:0] r;
      logic [63:0]  x, y, z, mask;
      int w, n;
      bit legal;
      legal = (opc == 5'h17 || opc == 5'h14 || opc == 5'h15);
      if (sz == 3 && !q) legal = 0;
      if (opc != 5'h17 && sz == 3) legal = 0;
      if (opc == 5'h17 && u) legal = 0;
      w = 8 << sz;
      mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
      cat = q ? {b, a} : {128'd0, b[63:0], a[63:0]};
      n = (q ? 128 : 64) / w;
      r = '0;
      for (int j = 0; j < n; j++) begin
         x = 64'(cat >> (2*j*w)) & mask;
         y = 64'(cat >> ((2*j+1)*w)) & mask;
         if (opc == 5'h17) z = (x + y) & mask;
         else begin
            bit xg;
            xg = u ? (x > y) : ($signed(x << (64-w)) > $signed(y << (64-w)));
            if (opc == 5'h14) z = xg ? x : y;
            else              z = xg ? y : x;
         end
         r = r | (128'(z) << (j*w));
      end
      return {legal, r};
   endfunction

   function automatic string tag(input bit q, input int sz, input logic [4:0] opc,
                                 input bit u);
      if (opc != 5'h17 && opc != 5'h14 && opc != 5'h15) return "R8";
      if (sz == 3 && !q) return "R6";
      if ((opc != 5'h17 && sz == 3) || (opc == 5'h17 && u)) return "R7";
      if (sz == 3) return "R5";
      if (!q) return "R4";
      if (opc == 5'h17) return "R1,R3";
      return "R2,R3";
   endfunction

   task automatic run_op(input bit q, input bit u, input int sz, input logic [4:0] opc,
                         input logic [4:0] rn, input logic [4:0] rm, input logic [4:0] rd,
                         input logic [127:0] marker);
      logic [128:0] exp;
      string t;
      load(rd, marker);
      exp = model(shadow[rn], shadow[rm], q, u, sz, opc);
      t = tag(q, sz, opc, u);
      @(negedge clk);
      in_valid = 1'b1;
      instr = {1'b0, q, u, 5'b01110, 2'(sz), 1'b1, rm, opc, 1'b1, rn, rd};
      @(negedge clk);
      in_valid = 1'b0;
      check(done === 1'b1, {t, " done pulse R9"}, 128'(done), 128'd1);
      check(undef === !exp[128], {t, " undef"}, 128'(undef), 128'(!exp[128]));
      peek_addr = rd;
      @(negedge clk);
      check(done === 1'b0, "R9 done one cycle", 128'(done), 128'd0);
      if (exp[128]) check(peek_data === exp[127:0], {t, " result"}, peek_data, exp[127:0]);
      else          check(peek_data === marker, {t, " dest kept"}, peek_data, marker);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [4:0] opcs [4];
      int k;
      opcs[0] = 5'h17; opcs[1] = 5'h14; opcs[2] = 5'h15; opcs[3] = 5'h16;
      for (int i = 0; i < 32; i++) shadow[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check(done === 1'b0 && undef === 1'b0, "R10 flags", 128'({done, undef}), 128'd0);
      peek_addr = 5'd7;
      #1 check(peek_data === '0, "R10 reg zero", peek_data, '0);
      // R11 load and read back
      load(5'd30, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
      peek_addr = 5'd30;
      #1 check(peek_data === 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, "R11 load",
               peek_data, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
      k = 0;
      for (int p = 0; p < 5; p++) begin
         for (int r = 0; r < 4; r++) begin
            logic [127:0] va, vb;
            if (p == 0) begin
               va = {8{16'h7F80}} ^ (128'h1 << (r*40));
               vb = {4{32'h8000_0000}} | {4{32'h0000_7FFF}};
            end else if (p == 1) begin
               va = {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF};
               vb = {16{8'hFF}} ^ {8{16'h0080}};
            end else begin
               va = {$urandom, $urandom, $urandom, $urandom};
               vb = {$urandom, $urandom, $urandom, $urandom};
            end
            load(5'(1 + r), va);
            load(5'(8 + r), vb);
         end
         for (int o = 0; o < 4; o++)
            for (int u = 0; u < 2; u++)
               for (int sz = 0; sz < 4; sz++)
                  for (int q = 0; q < 2; q++) begin
                     run_op(q[0], u[0], sz, opcs[o], 5'(1 + k % 4), 5'(8 + (k / 3) % 4),
                            5'(16 + k % 12), {4{32'hA5C3_0F1E}} ^ 128'(k));
                     k++;
                  end
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule